// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an external SDRAM out of power-up. A single word write to a fixed address window starts it. The data of that write plays no part and is not even brought into the block. Once started, the block drives the command pins (chip select, row strobe, column strobe, write enable), the bank address and the address pins on its own, through a fixed series of commands.

The series runs as follows. First comes a precharge of every bank, then a short idle gap. Next come eight auto-refresh commands, each with the same idle gap after it. Last comes a load of the mode register. The length of the idle gap comes from a 2-bit wait setting. The mode word is built from fixed settings: burst length 1, sequential wrap and CAS latency 2. A write-burst select input adds one more bit, and the whole word is placed on the address pins one position higher when the data bus is 16 bits wide.

The wait setting and the write-burst select are captured when the sequence starts. A done flag rises once the mode register has been loaded. A write that arrives while the sequence is running is dropped.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (no-operation), the bank and address pins are zero, and busy and done are low.
- R2: A start is accepted only when wr_en is high, the block is idle, and wr_addr masked by WIN_MASK equals WIN_BASE. A write outside the window leaves every output unchanged.
- R3: The first cycle after an accepted start carries the precharge-all command 0010 with address bit 10 high.
- R4: After the precharge come exactly wait_sel+1 cycles of no-operation 0111. The value used is the wait_sel captured at start.
- R5: Exactly eight refresh commands 0001 are issued. Each is followed by exactly wait_sel+1 no-operation cycles, so with P = wait_sel+2, refresh k (k = 1..8) appears P*k cycles after the precharge.
- R6: The mode-register load 0000 is the last command. It appears 9*P cycles after the precharge, and no-operation follows it.
- R7: During the mode-register load on a 16-bit bus, address bits [3:1] carry burst length 000, bit 4 carries the wrap type 0, bits [7:5] carry CAS latency 010, bit 10 carries the write-burst select, and bit 0 is 0. This gives 0x440 for single writes (single_wr=1) and 0x040 for burst writes.
- R8: done is low while the sequence runs and goes high in the cycle after the mode-register load. It stays high until the next accepted start, and it is never high together with busy.
- R9: While busy, a start write is ignored, and changes on wait_sel or single_wr do not alter the timing or the mode word of the running sequence.
- R10: The bank address pins stay zero throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe from the host bus |
| wr_addr | input | WADDR_W | Write address, decoded against the start window |
| wait_sel | input | 2 | Idle-gap setting, captured at start |
| single_wr | input | 1 | 1 = single-word writes, 0 = burst writes; captured at start |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | A_W | Address pins |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |

## Verification
Two events can meet in one cycle: a new start write, and the final mode-register load that hands over to done. The bench provokes this by placing a start write in the window on the exact cycle the load is on the pins. It then judges the result by checking three things: that the following cycle shows done high, busy low and no-operation, and that no precharge follows. A second overlap, a start write together with changed wait_sel and single_wr arriving during a refresh gap, is judged by confirming that the gap lengths and the mode word follow the values captured at the original start.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PALL,
    ST_GAP,
    ST_REF,
    ST_MRS
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PALL = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
endpackage

// File: rtl/sdram_start_decode.sv
module sdram_start_decode #(
  parameter int WADDR_W = 32,
  parameter logic [WADDR_W-1:0] WIN_BASE = 32'h2000_0000,
  parameter logic [WADDR_W-1:0] WIN_MASK = 32'hFFFF_0000
) (
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  output logic               hit
);
  always_comb hit = wr_en && ((wr_addr & WIN_MASK) == WIN_BASE);
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  always_comb expired = (cnt == '0);
endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int DATA_W = 16,
  parameter int A_W = 13,
  parameter logic [2:0] BL_CODE = 3'd0,
  parameter logic WRAP_CODE = 1'b0,
  parameter logic [2:0] CL_CODE = 3'd2
) (
  input  logic           single_wr,
  output logic [A_W-1:0] word
);
  localparam int SHIFT = (DATA_W == 32) ? 2 : ((DATA_W == 16) ? 1 : 0);

  logic [A_W-1:0] raw;

  always_comb begin
    raw = '0;
    raw[2:0] = BL_CODE;
    raw[3]   = WRAP_CODE;
    raw[6:4] = CL_CODE;
    raw[9]   = single_wr;
  end

  generate
    if (SHIFT == 0) begin : g_noshift
      always_comb word = raw;
    end else begin : g_shift
      always_comb word = {raw[A_W-1-SHIFT:0], {SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WADDR_W = 32,
  parameter logic [WADDR_W-1:0] WIN_BASE = 32'h2000_0000,
  parameter logic [WADDR_W-1:0] WIN_MASK = 32'hFFFF_0000,
  parameter int DATA_W = 16,
  parameter int A_W = 13,
  parameter int BA_W = 2,
  parameter int N_REF = 8,
  parameter int WAIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WAIT_W-1:0]  wait_sel,
  input  logic               single_wr,
  output logic               cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [BA_W-1:0]    ba,
  output logic [A_W-1:0]     addr,
  output logic               busy,
  output logic               done
);
  localparam int REF_CW = $clog2(N_REF + 1);
  localparam int AP_BIT = 10;

  seq_state_t state, nxt;
  logic [REF_CW-1:0] ref_cnt;
  logic [WAIT_W-1:0] wait_q;
  logic              single_q;
  logic              hit, start_ok, gap_load, gap_done;
  logic [A_W-1:0]    mode_word;
  logic [3:0]        cmd_nxt;

  sdram_start_decode #(.WADDR_W(WADDR_W), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
  );

  sdram_gap_timer #(.W(WAIT_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(wait_q), .expired(gap_done)
  );

  sdram_mode_word #(.DATA_W(DATA_W), .A_W(A_W)) u_mode (
    .single_wr(single_q), .word(mode_word)
  );

  always_comb start_ok = hit && (state == ST_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start_ok) nxt = ST_PALL;
      ST_PALL: nxt = ST_GAP;
      ST_GAP: begin
        if (gap_done) nxt = (ref_cnt == REF_CW'(N_REF)) ? ST_MRS : ST_REF;
      end
      ST_REF:  nxt = ST_GAP;
      ST_MRS:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb gap_load = (nxt == ST_GAP) && (state != ST_GAP);

  always_comb begin
    case (nxt)
      ST_PALL: cmd_nxt = CMD_PALL;
      ST_REF:  cmd_nxt = CMD_REF;
      ST_MRS:  cmd_nxt = CMD_MRS;
      default: cmd_nxt = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ref_cnt  <= '0;
      wait_q   <= '0;
      single_q <= 1'b0;
      done     <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      ba       <= '0;
      addr     <= '0;
    end else begin
      state <= nxt;
      {cs_n, ras_n, cas_n, we_n} <= cmd_nxt;
      ba <= '0;
      if (nxt == ST_PALL) begin
        addr <= '0;
        addr[AP_BIT] <= 1'b1;
      end else if (nxt == ST_MRS) begin
        addr <= mode_word;
      end else begin
        addr <= '0;
      end
      if (start_ok) begin
        wait_q   <= wait_sel;
        single_q <= single_wr;
        ref_cnt  <= '0;
        done     <= 1'b0;
      end
      if (nxt == ST_REF) ref_cnt <= ref_cnt + 1'b1;
      if (state == ST_MRS) done <= 1'b1;
    end
  end

  always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            busy,
  input logic            done
);
  logic [3:0] cmd;
  logic [3:0] refs_seen;

  always_comb cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst)                refs_seen <= '0;
    else if (cmd == 4'b0010) refs_seen <= '0;
    else if (cmd == 4'b0001) refs_seen <= refs_seen + 1'b1;
  end

  // R3
  pall_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cmd == 4'b0010);

  // R4
  gap_after_pall_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0010 |=> cmd == 4'b0111);

  // R5
  gap_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0001 |=> cmd == 4'b0111);

  // R5
  ref_total_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0000 |-> refs_seen == 4'd8);

  // R8
  done_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0000 |=> done && !busy);

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R10
  bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ba == '0);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .busy(busy), .done(done)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  localparam int A_W = 13;
  localparam int BA_W = 2;
  localparam logic [31:0] IN_WIN  = 32'h2000_0A42;
  localparam logic [31:0] OUT_WIN = 32'h2001_0000;

  typedef struct packed {
    logic [1:0]     w;
    logic           sw;
    logic [A_W-1:0] exp_a;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b1, 13'h440}, '{2'd0, 1'b0, 13'h040},
    '{2'd1, 1'b1, 13'h440}, '{2'd2, 1'b0, 13'h040},
    '{2'd3, 1'b1, 13'h440}, '{2'd3, 1'b0, 13'h040},
    '{2'd1, 1'b0, 13'h040}, '{2'd2, 1'b1, 13'h440}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [1:0] wait_sel = '0;
  logic single_wr = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, busy, done;
  logic [BA_W-1:0] ba;
  logic [A_W-1:0] addr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wait_sel(wait_sel), .single_wr(single_wr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // Runs one full sequence; dist_t >= 0 injects a start write and flipped settings at that cycle.
  task automatic run_seq(input logic [1:0] w, input logic sw, input logic [A_W-1:0] exp_a, input int dist_t);
    int p, last;
    logic [3:0] ecmd;
    string tag;
    p = w + 2;
    last = 9 * p + 1;
    wait_sel = w;
    single_wr = sw;
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = IN_WIN;
    @(negedge clk);
    for (int t = 0; t <= last; t++) begin
      if (t == 0)              begin ecmd = 4'b0010; tag = "R3"; end
      else if (t == last - 1)  begin ecmd = 4'b0000; tag = "R6"; end
      else if (t == last)      begin ecmd = 4'b0111; tag = "R8"; end
      else if (t % p == 0)     begin ecmd = 4'b0001; tag = "R5"; end
      else                     begin ecmd = 4'b0111; tag = "R4"; end
      if (dist_t >= 0) tag = {tag, "/R9"};
      check(tag, $sformatf("cmd t=%0d w=%0d", t, w), {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, ecmd});
      check("R8", $sformatf("done/busy t=%0d", t), {30'd0, done, busy},
            {30'd0, (t == last), (t != last)});
      if (t == 0) check("R3", "addr bit10", {31'd0, addr[10]}, 32'd1);
      if (t == last - 1) check(dist_t >= 0 ? "R7/R9" : "R7", "mode addr", {19'd0, addr}, {19'd0, exp_a});
      if (ba != '0) check("R10", "bank", {30'd0, ba}, 32'd0);
      if (t == dist_t) begin
        wr_en = 1'b1;
        wr_addr = IN_WIN;
        wait_sel = ~w;
        single_wr = ~sw;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R10", "bank end", {30'd0, ba}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
    check("R1", "addr", {19'd0, addr}, 32'd0);
    check("R1", "ba", {30'd0, ba}, 32'd0);
    check("R1", "busy/done", {30'd0, busy, done}, 32'd0);

    // R2 write outside the window before any start
    wr_en = 1'b1; wr_addr = OUT_WIN;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R2", "out-of-window busy/done", {30'd0, busy, done}, 32'd0);
    check("R2", "out-of-window cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);

    for (int i = 0; i < 8; i++) run_seq(VEC[i].w, VEC[i].sw, VEC[i].exp_a, -1);

    // R9: start plus changed settings during a refresh gap
    run_seq(2'd1, 1'b1, 13'h440, 4);
    // R9: start write on the cycle of the mode-register load
    run_seq(2'd2, 1'b0, 13'h040, 9 * 4);
    repeat (2) begin
      check("R9", "after load collision busy/done", {30'd0, busy, done}, 32'h1);
      check("R9", "after load collision cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);
      @(negedge clk);
    end

    // R2 outside-window write after done leaves done high and no command
    wr_en = 1'b1; wr_addr = OUT_WIN;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2", "out-of-window after done busy/done", {30'd0, busy, done}, 32'h1);
    check("R2", "out-of-window after done cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);

    // R8 restart clears done (checked at t=0 inside run_seq)
    run_seq(2'd0, 1'b1, 13'h440, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog got hang exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule